// File: doc/BRIEF.md
# Indirect SRAM Access Bridge

This block lets a host reach an internal memory of 32-bit words through a handful of byte-wide registers. The host claims the memory by setting two ownership bits, picks read or write and single or burst access in a control register, and loads a word address. In read mode, loading the address fetches the word into four read-data byte registers. In write mode, the host fills four write-data byte registers and a 4-bit byte-enable mask. Writing the top data byte starts the memory write.

In burst mode the word address steps by one after each completed write, and after each host read of the top read-data byte. In single mode it holds. A ready flag drops while a memory cycle is in flight. A set of sticky exception flags records misuse. A status byte carries two 4-bit counters of operations started and finished, which agree whenever the bridge is idle. A recovery sequence clears the exception flags: set the clear bit, write the top write-data byte as a dummy, then read the top read-data byte. A free-running beat counter lets the host tell whether time moved on during its transaction.

Register map (5-bit register address): 0x00 recovery (bit0 clear), 0x01 ownership (bit0 request, bit1 select), 0x02 mode (bit0 write, bit1 burst), 0x03 byte enables, 0x04 address low, 0x05 address high, 0x06 status (bit0 ready), 0x07 exceptions, 0x08 op counters, 0x09 beat, 0x10-0x13 write-data bytes 0-3, 0x14-0x17 read-data bytes 0-3.

Top module: `sram_window_bridge`

## Requirements
- R1: After reset, status reads 0x01 (ready), exceptions read 0x00, op counters read 0x00 and the read-data bytes read 0x00.
- R2: While ownership bits 0 and 1 are not both set, address writes and top write-byte writes start no memory cycle and change neither the address nor memory, and ready stays 1.
- R3: Writing write-data byte 3 (0x13), owned and in write mode, writes the word. Byte lane i (bits 8i+7:8i) is updated only when enable bit i is set, so byte 3 is kept when bit 3 is clear.
- R4: A write holds ready at 0 for exactly one cycle after the trigger. An address load in read mode holds ready at 0 for two cycles and then presents the addressed word in read-data bytes 0-3 (byte i = bits 8i+7:8i).
- R5: In burst mode the address increments after each write and on each host read of read-data byte 3 (0x17), which also prefetches the next word. In single mode the address holds.
- R6: An increment from the last word (255) wraps to 0 and sets exception bit 4.
- R7: Writing a nonzero value to the address high register (0x05) sets exception bit 0.
- R8: While not ready, a top write-byte write sets bit 3, a read-data read sets bit 2, and an address-low write sets bit 5 and leaves the address unchanged.
- R9: A top write-byte write in read mode sets exception bit 1 and starts no cycle.
- R10: Whenever ready is 1, the high and low nibbles of the op-counter register are equal.
- R11: Exception flags are sticky. They clear only through the recovery sequence: clear bit set, dummy write of 0x13, then a read of 0x17.
- R12: The beat register holds a 4-bit counter in bits 3:0 with bits 7:4 zero. It advances once every 16 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe (drives read side effects) |
| regRdData | output | 8 | Register read data, combinational from regAddr |

## Verification
The bench fills all 256 words in a burst write, then reads them all back in a burst read. Both passes end on the wrap, so a design that failed to wrap or to flag it would miscompare or show a wrong exception byte. All sixteen byte-enable masks are written and read back against a computed merge. A design that triggered on the wrong byte, or that wrote byte 3 when its enable was clear, corrupts the words. Back-to-back accesses are aimed at the busy cycles, and unowned writes at known words. A bridge that accepted an address change mid-cycle or wrote without ownership returns the wrong data. The recovery sequence and the beat cadence are also checked at the register interface.

// File: rtl/sram_win_pkg.sv
package sram_win_pkg;
  localparam logic [4:0] RA_CFG   = 5'h00;
  localparam logic [4:0] RA_OWN   = 5'h01;
  localparam logic [4:0] RA_CTL   = 5'h02;
  localparam logic [4:0] RA_BEN   = 5'h03;
  localparam logic [4:0] RA_ADDRL = 5'h04;
  localparam logic [4:0] RA_ADDRH = 5'h05;
  localparam logic [4:0] RA_STAT  = 5'h06;
  localparam logic [4:0] RA_EXC   = 5'h07;
  localparam logic [4:0] RA_HWST  = 5'h08;
  localparam logic [4:0] RA_BEAT  = 5'h09;
  localparam logic [4:0] RA_WD3   = 5'h13;
  localparam logic [4:0] RA_RD3   = 5'h17;
  localparam logic [2:0] WD_PAGE  = 3'b100;
  localparam logic [2:0] RD_PAGE  = 3'b101;

  localparam int EXC_IFACE = 0;
  localparam int EXC_XCT   = 1;
  localparam int EXC_RD    = 2;
  localparam int EXC_WR    = 3;
  localparam int EXC_WRAP  = 4;
  localparam int EXC_ADDR  = 5;
  localparam int EXC_W     = 6;

  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic memWrite;
    logic memRead;
    logic capture;
  } strb_t;

  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD1, PH_RD2} phase_t;
endpackage

// File: rtl/sram_win_ctrl.sv
module sram_win_ctrl
  import sram_win_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [4:0]       regAddr,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  input  logic             regRdEn,
  input  logic             addrAtMax,
  output strb_t            strb,
  output logic             ready,
  output logic             owned,
  output logic             clearEvt,
  output logic             cfgClr,
  output logic [1:0]       ownBits,
  output logic [1:0]       modeBits,
  output logic [EXC_W-1:0] excFlags,
  output logic [7:0]       hwStatus
);
  phase_t phase, nextPhase;
  logic clrArmed, armSet, startOp, doneOp;
  logic [EXC_W-1:0] setFlags;
  logic [3:0] startCnt, doneCnt;
  logic wrTop, rdTop, rdAny, wrAddrLo, wrAddrHi, idle, writeMode, burst;

  assign idle      = (phase == PH_IDLE);
  assign ready     = idle;
  assign owned     = ownBits[0] & ownBits[1];
  assign writeMode = modeBits[0];
  assign burst     = modeBits[1];
  assign wrTop     = regWrEn && (regAddr == RA_WD3);
  assign rdTop     = regRdEn && (regAddr == RA_RD3);
  assign rdAny     = regRdEn && (regAddr[4:2] == RD_PAGE);
  assign wrAddrLo  = regWrEn && (regAddr == RA_ADDRL);
  assign wrAddrHi  = regWrEn && (regAddr == RA_ADDRH);
  assign hwStatus  = {startCnt, doneCnt};

  always_comb begin
    strb      = '0;
    nextPhase = phase;
    setFlags  = '0;
    startOp   = 1'b0;
    doneOp    = 1'b0;
    clearEvt  = 1'b0;
    armSet    = 1'b0;
    case (phase)
      PH_WR: begin
        strb.memWrite = 1'b1;
        strb.incAddr  = burst;
        nextPhase     = PH_IDLE;
        doneOp        = 1'b1;
      end
      PH_RD1: begin
        strb.memRead = 1'b1;
        nextPhase    = PH_RD2;
      end
      PH_RD2: begin
        strb.capture = 1'b1;
        nextPhase    = PH_IDLE;
        doneOp       = 1'b1;
      end
      default: ;
    endcase
    if (owned) begin
      if (wrAddrLo) begin
        if (!idle) setFlags[EXC_ADDR] = 1'b1;
        else begin
          strb.loadAddr = 1'b1;
          if (!writeMode) begin
            nextPhase = PH_RD1;
            startOp   = 1'b1;
          end
        end
      end
      if (wrAddrHi && (regWrData != 8'h00)) setFlags[EXC_IFACE] = 1'b1;
      if (wrTop) begin
        if (cfgClr) armSet = 1'b1;
        else if (!idle) setFlags[EXC_WR] = 1'b1;
        else if (!writeMode) setFlags[EXC_XCT] = 1'b1;
        else begin
          nextPhase = PH_WR;
          startOp   = 1'b1;
        end
      end
      if (rdAny && !idle) setFlags[EXC_RD] = 1'b1;
      if (rdTop && idle) begin
        if (cfgClr && clrArmed) clearEvt = 1'b1;
        else if (!writeMode && burst) begin
          strb.incAddr = 1'b1;
          nextPhase    = PH_RD1;
          startOp      = 1'b1;
        end
      end
    end
    if (strb.incAddr && addrAtMax) setFlags[EXC_WRAP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cfgClr   <= 1'b0;
      ownBits  <= 2'b00;
      modeBits <= 2'b00;
      clrArmed <= 1'b0;
      excFlags <= '0;
      startCnt <= 4'h0;
      doneCnt  <= 4'h0;
    end else begin
      phase <= nextPhase;
      if (regWrEn && regAddr == RA_CFG) cfgClr   <= regWrData[0];
      if (regWrEn && regAddr == RA_OWN) ownBits  <= regWrData[1:0];
      if (regWrEn && regAddr == RA_CTL) modeBits <= regWrData[1:0];
      if (!cfgClr) clrArmed <= 1'b0;
      else if (armSet) clrArmed <= 1'b1;
      else if (clearEvt) clrArmed <= 1'b0;
      excFlags <= clearEvt ? '0 : (excFlags | setFlags);
      startCnt <= startCnt + {3'b000, startOp};
      doneCnt  <= clearEvt ? startCnt : (doneCnt + {3'b000, doneOp});
    end
  end
endmodule

// File: rtl/sram_win_dpath.sv
module sram_win_dpath
  import sram_win_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BEAT_DIV = 16,
  parameter int BEAT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  strb_t             strb,
  output logic [ADDR_W-1:0] addrQ,
  output logic              addrAtMax,
  output logic [3:0]        benQ,
  output logic [3:0][7:0]   wrBytes,
  output logic [3:0][7:0]   rdBytes,
  output logic [BEAT_W-1:0] beatQ
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DIV_W = (BEAT_DIV > 1) ? $clog2(BEAT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BEAT_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [3:0][7:0] sramQ;

  assign addrAtMax = (addrQ == {ADDR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      benQ    <= 4'h0;
      wrBytes <= '0;
      rdBytes <= '0;
      divCnt  <= '0;
      beatQ   <= '0;
    end else begin
      if (strb.loadAddr) addrQ <= regWrData[ADDR_W-1:0];
      else if (strb.incAddr) addrQ <= addrQ + 1'b1;
      if (regWrEn && regAddr == RA_BEN) benQ <= regWrData[3:0];
      if (regWrEn && regAddr[4:2] == WD_PAGE) wrBytes[regAddr[1:0]] <= regWrData;
      if (strb.capture) rdBytes <= sramQ;
      if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        beatQ  <= beatQ + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.memWrite && benQ[g]) laneMem[addrQ] <= wrBytes[g];
      if (strb.memRead) sramQ[g] <= laneMem[addrQ];
    end
  end
endmodule

// File: rtl/sram_window_bridge.sv
module sram_window_bridge
  import sram_win_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BEAT_DIV = 16,
  parameter int BEAT_W   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData
);
  strb_t strb;
  logic ready, owned, clearEvt, cfgClr, addrAtMax;
  logic [1:0] ownBits, modeBits;
  logic [EXC_W-1:0] excFlags;
  logic [7:0] hwStatus;
  logic [ADDR_W-1:0] addrQ;
  logic [3:0] benQ;
  logic [3:0][7:0] wrBytes, rdBytes;
  logic [BEAT_W-1:0] beatQ;

  sram_win_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .addrAtMax(addrAtMax),
    .strb(strb), .ready(ready), .owned(owned), .clearEvt(clearEvt),
    .cfgClr(cfgClr), .ownBits(ownBits), .modeBits(modeBits),
    .excFlags(excFlags), .hwStatus(hwStatus)
  );

  sram_win_dpath #(.ADDR_W(ADDR_W), .BEAT_DIV(BEAT_DIV), .BEAT_W(BEAT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strb(strb), .addrQ(addrQ), .addrAtMax(addrAtMax),
    .benQ(benQ), .wrBytes(wrBytes), .rdBytes(rdBytes), .beatQ(beatQ)
  );

  always_comb begin
    regRdData = 8'h00;
    if (regAddr[4:2] == WD_PAGE) regRdData = wrBytes[regAddr[1:0]];
    else if (regAddr[4:2] == RD_PAGE) regRdData = rdBytes[regAddr[1:0]];
    else begin
      case (regAddr)
        RA_CFG:   regRdData = {7'b0, cfgClr};
        RA_OWN:   regRdData = {6'b0, ownBits};
        RA_CTL:   regRdData = {6'b0, modeBits};
        RA_BEN:   regRdData = {4'b0, benQ};
        RA_ADDRL: regRdData = 8'(addrQ);
        RA_STAT:  regRdData = {7'b0, ready};
        RA_EXC:   regRdData = 8'(excFlags);
        RA_HWST:  regRdData = hwStatus;
        RA_BEAT:  regRdData = 8'(beatQ);
        default:  regRdData = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/sram_win_checker.sv
module sram_win_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ready,
  input logic       owned,
  input logic       memWrite,
  input logic       incAddr,
  input logic       addrAtMax,
  input logic       clearEvt,
  input logic [5:0] excFlags,
  input logic [7:0] hwStatus
);
  p_write_owned_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> $past(owned));
  p_write_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> ready);
  p_write_after_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> $past(ready));
  p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (incAddr && addrAtMax) |=> excFlags[4]);
  p_idle_nibbles_r10: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (hwStatus[7:4] == hwStatus[3:0]));
  p_sticky_exc_r11: assert property (@(posedge clk) disable iff (!rstN)
    !clearEvt |=> ((excFlags & $past(excFlags)) == $past(excFlags)));
endmodule

bind sram_window_bridge sram_win_checker u_chk (
  .clk(clk), .rstN(rstN), .ready(ready), .owned(owned),
  .memWrite(strb.memWrite), .incAddr(strb.incAddr), .addrAtMax(addrAtMax),
  .clearEvt(clearEvt), .excFlags(excFlags), .hwStatus(hwStatus)
);

// File: tb/sram_window_bridge_bench.sv
module sram_window_bridge_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [7:0] regRdData;
  int checks = 0;
  int fails = 0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  sram_window_bridge u_sram_window_bridge (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  function automatic logic [31:0] pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, b + 8'd3, ~b, b * 8'd7};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitReady();
    logic [7:0] s;
    for (int k = 0; k < 20; k++) begin
      rd(5'h06, s);
      if (s[0]) return;
    end
    check("R4 ready timeout", 0, 1);
  endtask

  task automatic readWord(output logic [31:0] w);
    logic [7:0] b;
    for (int g = 0; g < 4; g++) begin
      rd(5'h14 + 5'(g), b);
      w[8*g +: 8] = b;
    end
  endtask

  task automatic recover();
    logic [7:0] d;
    wr(5'h00, 8'h01);
    wr(5'h13, 8'h00);
    rd(5'h17, d);
    wr(5'h00, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h06, d); check("R1 status", d, 8'h01);
    rd(5'h07, d); check("R1 exceptions", d, 8'h00);
    rd(5'h08, d); check("R1 op counters", d, 8'h00);
    readWord(w); check("R1 read data", w, 0);

    // Burst fill of every word; R3 R4 R5 R6
    wr(5'h01, 8'h03);
    wr(5'h02, 8'h03);
    wr(5'h03, 8'h0F);
    wr(5'h04, 8'h00);
    for (int i = 0; i < 256; i++) begin
      w = pat(i);
      model[i] = w;
      for (int g = 0; g < 4; g++) wr(5'h10 + 5'(g), w[8*g +: 8]);
      if (i == 0) begin
        rd(5'h06, d); check("R4 write busy cycle", d, 8'h00);
        rd(5'h06, d); check("R4 write ready again", d, 8'h01);
      end else waitReady();
    end
    rd(5'h04, d); check("R6 address wrapped", d, 8'h00);
    rd(5'h07, d); check("R6 wrap flag", d, 8'h10);
    rd(5'h08, d); check("R10 nibbles equal", {28'h0, d[7:4]}, {28'h0, d[3:0]});

    // Burst read back of every word; R4 R5
    wr(5'h02, 8'h02);
    wr(5'h04, 8'h00);
    rd(5'h06, d); check("R4 read busy 1", d, 8'h00);
    rd(5'h06, d); check("R4 read busy 2", d, 8'h00);
    rd(5'h06, d); check("R4 read ready", d, 8'h01);
    for (int i = 0; i < 256; i++) begin
      waitReady();
      readWord(w);
      check($sformatf("R5 burst word %0d", i), w, model[i]);
    end
    waitReady();
    rd(5'h04, d); check("R6 read wrap address", d, 8'h00);

    // R11 recovery
    recover();
    rd(5'h07, d); check("R11 exceptions cleared", d, 8'h00);

    // R2 ownership gate
    wr(5'h01, 8'h01);
    wr(5'h02, 8'h01);
    wr(5'h04, 8'h07);
    for (int g = 0; g < 4; g++) wr(5'h10 + 5'(g), 8'hEE);
    rd(5'h06, d); check("R2 no busy when unowned", d, 8'h01);
    rd(5'h04, d); check("R2 address unchanged", d, 8'h00);
    wr(5'h01, 8'h03);
    wr(5'h02, 8'h00);
    wr(5'h04, 8'h07);
    waitReady();
    readWord(w); check("R2 word intact", w, model[7]);

    // R5 single read holds address
    wr(5'h04, 8'h0A);
    waitReady();
    rd(5'h17, d); rd(5'h17, d2);
    rd(5'h04, d); check("R5 single read holds", d, 8'h0A);
    readWord(w); check("R5 single data", w, model[10]);

    // R3 byte-enable sweep
    for (int b = 0; b < 16; b++) begin
      wr(5'h02, 8'h01);
      wr(5'h03, 8'(b));
      wr(5'h04, 8'(8'h40 + b));
      for (int g = 0; g < 4; g++) begin
        wr(5'h10 + 5'(g), 8'(16 * g + b) ^ 8'hE0);
        if (b[g]) model[8'h40 + b][8*g +: 8] = 8'(16 * g + b) ^ 8'hE0;
      end
      waitReady();
      rd(5'h04, d); check("R5 single write holds", d, 8'(8'h40 + b));
    end
    wr(5'h02, 8'h00);
    for (int b = 0; b < 16; b++) begin
      wr(5'h04, 8'(8'h40 + b));
      waitReady();
      readWord(w);
      check($sformatf("R3 enable mask %0d", b), w, model[8'h40 + b]);
    end

    // R7 nonzero address high
    wr(5'h05, 8'h01);
    rd(5'h07, d); check("R7 interface error", d, 8'h01);
    recover();
    wr(5'h05, 8'h00);
    rd(5'h07, d); check("R7 zero high no flag", d, 8'h00);

    // R8 busy errors
    wr(5'h02, 8'h01);
    wr(5'h03, 8'h0F);
    wr(5'h04, 8'h03);
    wr(5'h13, model[3][31:24]);
    wr(5'h13, model[3][31:24]);
    waitReady();
    wr(5'h02, 8'h00);
    wr(5'h04, 8'h03);
    rd(5'h14, d);
    wr(5'h04, 8'h09);
    waitReady();
    rd(5'h07, d); check("R8 busy flags", d, 8'h2C);
    rd(5'h04, d); check("R8 address kept", d, 8'h03);
    recover();

    // R9 wrong transaction type
    wr(5'h13, 8'h99);
    rd(5'h06, d); check("R9 no cycle", d, 8'h01);
    rd(5'h07, d); check("R9 type flag", d, 8'h02);
    recover();
    rd(5'h07, d); check("R11 cleared again", d, 8'h00);
    rd(5'h08, d); check("R10 nibbles idle", {28'h0, d[7:4]}, {28'h0, d[3:0]});

    // R12 beat counter
    rd(5'h09, d);
    repeat (63) @(negedge clk);
    rd(5'h09, d2);
    check("R12 upper bits", {24'h0, d2[7:4]}, 0);
    check("R12 beat step", {28'h0, 4'(d2[3:0] - d[3:0])}, 4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule